// File: doc/BRIEF.md
# Decode-Stage Hazard Interlock for a Three-Path In-Order Pipeline

This block sits in the decode stage of a single-issue, in-order pipeline. The front end runs fetch, micro-op conversion, decode and register read. After register read, each micro-op takes one of three execution paths: an integer path (one ALU stage, then write-back), a memory path (ALU address stage, three memory stages, then write-back) or a floating-point path (four FP stages, then write-back). The interlock keeps a short record of the in-flight micro-ops that will write a register: their destination, their path and how far each has advanced. Each cycle it compares the source registers of the micro-op in decode against this record. It raises `stall` until every operand the micro-op uses can be obtained in time. It also reports, for each operand, which result path the datapath must forward from.

A build-time parameter selects one of two modes. With no bypassing, a consumer may leave register read only in or after the cycle its producer is in write-back (the register file writes early in the cycle and reads late). With full bypassing, a result can be forwarded once the producer's last compute stage is complete. Stores consume their two operands at different points: the address at entry to the ALU stage, and the data one stage later at entry to the first memory stage. While `stall` is high, decode and the earlier stages hold their contents, register read receives a bubble, and in-flight producers keep advancing. The register file has unlimited write ports, so write-back conflicts never cause a stall.

Top module: `pil_interlock`

## Requirements
- R1: After reset no producer is tracked: a valid micro-op presented in the first cycle after reset sees `stall` low and both forward selects at 0.
- R2: With bypassing off, a consumer stalls for max(0, R − g) cycles on a dependent source, where g is the number of cycles between its producer's issue and its own presentation, and R is 1 for an integer add (kind 0), 4 for a load (kind 1) and 4 for an FP add (kind 3). The kind encoding is 0 integer add, 1 load, 2 store and 3 FP add.
- R3: With bypassing on, an operand needed at entry to the first execution stage stalls for max(0, R − 1 − g) cycles. This covers all sources of integer adds, loads and FP adds, and the address (source A) of a store.
- R4: With bypassing on, a store's data operand (source B) stalls for max(0, R − 2 − g) cycles, so a store may issue while only its data is still pending.
- R5: A micro-op stalls only on a source it uses and only against a register-writing producer. A load ignores source B, a store writes no register, and operands that match no in-flight destination never stall.
- R6: Each forward select is 0 for register file, 1 for integer ALU result, 2 for memory result and 3 for FP result. With bypassing on, at issue a select names the path of the youngest matching producer that is still fewer than R stages past register read. Otherwise the select is 0; with bypassing off it is always 0.
- R7: A decode slot with `dec_valid` low inserts nothing into the pipeline, and a stall cycle sends a bubble into register read. A later reader of the destination shown in an invalid slot does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds a micro-op |
| dec_kind | input | 2 | Micro-op kind (0 int add, 1 load, 2 store, 3 FP add) |
| dec_src_a | input | REG_W | Source A (first operand / address) |
| dec_src_b | input | REG_W | Source B (second operand / store data) |
| dec_dst | input | REG_W | Destination register |
| stall | output | 1 | Hold decode and earlier stages, bubble into register read |
| fwd_a | output | 2 | Forward select for source A |
| fwd_b | output | 2 | Forward select for source B |

## Verification
`stall` and both forward selects are combinational from the tracked state and the decode inputs. They are due in the same cycle the inputs are shown. The bench drives inputs on the falling edge and samples one nanosecond later, so each value read belongs to the current tracked state. A micro-op that issues on a rising edge is counted at position 0 from the next falling edge. The expected stall count for a gap of g idle slots is therefore computed from the producer starting at position g and advancing one position per cycle. The forward selects are read in the cycle in which `stall` first drops, when the producer sits at position g plus the stall count.

// File: rtl/pil_pkg.sv
package pil_pkg;

    typedef enum logic [1:0] {
        KIND_INT   = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_FP    = 2'd3
    } uop_kind_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_ALU = 2'd1,
        FWD_MEM = 2'd2,
        FWD_FP  = 2'd3
    } fwd_src_e;

    // Position after register read at whose end the result exists.
    function automatic int ready_pos(uop_kind_e k, int alu_st, int mem_st, int fp_st);
        case (k)
            KIND_INT:  return alu_st;
            KIND_LOAD: return alu_st + mem_st;
            KIND_FP:   return fp_st;
            default:   return 0;
        endcase
    endfunction

    function automatic logic writes_reg(uop_kind_e k);
        return k != KIND_STORE;
    endfunction

    function automatic fwd_src_e path_of(uop_kind_e k);
        case (k)
            KIND_INT:  return FWD_ALU;
            KIND_LOAD: return FWD_MEM;
            KIND_FP:   return FWD_FP;
            default:   return FWD_RF;
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pil_tracker.sv
module pil_tracker
    import pil_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  uop_kind_e                   in_kind,
    input  logic [REG_W-1:0]            in_dst,
    output logic [DEPTH-1:0]            trk_valid,
    output logic [DEPTH-1:0][1:0]       trk_kind,
    output logic [DEPTH-1:0][REG_W-1:0] trk_dst
);

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_valid <= '0;
            trk_kind  <= '0;
            trk_dst   <= '0;
        end else begin
            trk_valid[0] <= in_valid && writes_reg(in_kind);
            trk_kind[0]  <= in_kind;
            trk_dst[0]   <= in_dst;
            for (int i = 1; i < DEPTH; i++) begin
                trk_valid[i] <= trk_valid[i-1];
                trk_kind[i]  <= trk_kind[i-1];
                trk_dst[i]   <= trk_dst[i-1];
            end
        end
    end

endmodule

// File: rtl/pil_src_check.sv
module pil_src_check
    import pil_pkg::*;
#(
    parameter int   REG_W  = 5,
    parameter int   DEPTH  = 4,
    parameter bit   BYPASS = 1'b1,
    parameter int   ALU_ST = 1,
    parameter int   MEM_ST = 3,
    parameter int   FP_ST  = 4,
    parameter int   NEED_W = 4
) (
    input  logic                        use_i,
    input  logic [REG_W-1:0]            src_i,
    input  logic [NEED_W-1:0]           need_i,
    input  logic [DEPTH-1:0]            trk_valid,
    input  logic [DEPTH-1:0][1:0]       trk_kind,
    input  logic [DEPTH-1:0][REG_W-1:0] trk_dst,
    output logic                        hazard_o,
    output fwd_src_e                    fwd_o
);

    logic      hit;
    int        hit_pos;
    uop_kind_e hit_kind;
    int        rdy;
    int        limit;

    // Youngest match wins: scan from oldest to youngest, last hit stays.
    always_comb begin
        hit      = 1'b0;
        hit_pos  = 0;
        hit_kind = KIND_INT;
        for (int p = DEPTH - 1; p >= 0; p--) begin
            if (trk_valid[p] && trk_dst[p] == src_i) begin
                hit      = 1'b1;
                hit_pos  = p;
                hit_kind = uop_kind_e'(trk_kind[p]);
            end
        end
    end

    always_comb begin
        rdy   = ready_pos(hit_kind, ALU_ST, MEM_ST, FP_ST);
        limit = BYPASS ? (rdy - int'(need_i)) : rdy;
        hazard_o = use_i && hit && (hit_pos < limit);
        if (BYPASS && use_i && hit && (hit_pos < rdy))
            fwd_o = path_of(hit_kind);
        else
            fwd_o = FWD_RF;
    end

endmodule

// File: rtl/pil_interlock.sv
module pil_interlock
    import pil_pkg::*;
#(
    parameter bit BYPASS = 1'b1,
    parameter int REG_W  = 5,
    parameter int ALU_ST = 1,
    parameter int MEM_ST = 3,
    parameter int FP_ST  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [1:0]       dec_kind,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [REG_W-1:0] dec_dst,
    output logic             stall,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b
);

    localparam int DEPTH  = max3(ALU_ST, ALU_ST + MEM_ST, FP_ST);
    localparam int NEED_W = $clog2(ALU_ST + 2) + 1;
    localparam int NSRC   = 2;

    uop_kind_e                   kind;
    logic [DEPTH-1:0]            trk_valid;
    logic [DEPTH-1:0][1:0]       trk_kind;
    logic [DEPTH-1:0][REG_W-1:0] trk_dst;

    logic [NSRC-1:0]             src_use;
    logic [NSRC-1:0][REG_W-1:0]  src_reg;
    logic [NSRC-1:0][NEED_W-1:0] src_need;
    logic [NSRC-1:0]             src_haz;
    fwd_src_e                    src_fwd [NSRC];

    assign kind = uop_kind_e'(dec_kind);

    // Operand use and the stage at whose entry each operand is consumed.
    always_comb begin
        src_use[0]  = dec_valid;
        src_use[1]  = dec_valid && (kind != KIND_LOAD);
        src_reg[0]  = dec_src_a;
        src_reg[1]  = dec_src_b;
        src_need[0] = NEED_W'(1);
        src_need[1] = (kind == KIND_STORE) ? NEED_W'(ALU_ST + 1) : NEED_W'(1);
    end

    pil_tracker #(
        .REG_W (REG_W),
        .DEPTH (DEPTH)
    ) i_tracker (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dec_valid && !stall),
        .in_kind   (kind),
        .in_dst    (dec_dst),
        .trk_valid (trk_valid),
        .trk_kind  (trk_kind),
        .trk_dst   (trk_dst)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        pil_src_check #(
            .REG_W  (REG_W),
            .DEPTH  (DEPTH),
            .BYPASS (BYPASS),
            .ALU_ST (ALU_ST),
            .MEM_ST (MEM_ST),
            .FP_ST  (FP_ST),
            .NEED_W (NEED_W)
        ) i_chk (
            .use_i     (src_use[s]),
            .src_i     (src_reg[s]),
            .need_i    (src_need[s]),
            .trk_valid (trk_valid),
            .trk_kind  (trk_kind),
            .trk_dst   (trk_dst),
            .hazard_o  (src_haz[s]),
            .fwd_o     (src_fwd[s])
        );
    end

    assign stall = |src_haz;
    assign fwd_a = src_fwd[0];
    assign fwd_b = src_fwd[1];

endmodule

// File: rtl/pil_interlock_chk.sv
module pil_interlock_chk
    import pil_pkg::*;
#(
    parameter bit BYPASS = 1'b1,
    parameter int REG_W  = 5,
    parameter int DEPTH  = 4,
    parameter int MAXR   = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        dec_valid,
    input logic [1:0]                  dec_kind,
    input logic [REG_W-1:0]            dec_dst,
    input logic                        stall,
    input logic [1:0]                  fwd_a,
    input logic [1:0]                  fwd_b,
    input logic [DEPTH-1:0]            trk_valid
);

    int unsigned stall_run;

    always_ff @(posedge clk) begin
        if (rst) stall_run <= 0;
        else     stall_run <= stall ? stall_run + 1 : 0;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (trk_valid == '0));                                  // R1

    AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        stall_run <= MAXR);                                                 // R2

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !stall);                                             // R5

    AST_EMPTY_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (trk_valid == '0) |-> !stall);                                      // R5

    AST_NOBYP_FROM_RF: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !BYPASS) |-> (fwd_a == 2'd0 && fwd_b == 2'd0));       // R6

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        stall |=> !trk_valid[0]);                                           // R7

    AST_IDLE_INSERTS_NOTHING: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> !trk_valid[0]);                                      // R7

    AST_ISSUE_TRACKED: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !stall && dec_kind != 2'd2) |=> trk_valid[0]);        // R5

endmodule

bind pil_interlock pil_interlock_chk #(
    .BYPASS (BYPASS),
    .REG_W  (REG_W),
    .DEPTH  (DEPTH),
    .MAXR   (DEPTH)
) i_pil_interlock_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .dec_kind  (dec_kind),
    .dec_dst   (dec_dst),
    .stall     (stall),
    .fwd_a     (fwd_a),
    .fwd_b     (fwd_b),
    .trk_valid (trk_valid)
);

// File: tb/test_pil_interlock.sv
`timescale 1ns/1ps
module test_pil_interlock;

    localparam int RW  = 5;
    localparam int ALU = 1;
    localparam int MEM = 3;
    localparam int FP  = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic          dv  [2];
    logic [1:0]    dk  [2];
    logic [RW-1:0] dsa [2];
    logic [RW-1:0] dsb [2];
    logic [RW-1:0] dd  [2];
    logic          st  [2];
    logic [1:0]    fa  [2];
    logic [1:0]    fb  [2];

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    pil_interlock #(.BYPASS(1'b0), .REG_W(RW), .ALU_ST(ALU), .MEM_ST(MEM), .FP_ST(FP)) i_pil_interlock (
        .clk(clk), .rst(rst), .dec_valid(dv[0]), .dec_kind(dk[0]),
        .dec_src_a(dsa[0]), .dec_src_b(dsb[0]), .dec_dst(dd[0]),
        .stall(st[0]), .fwd_a(fa[0]), .fwd_b(fb[0]));

    pil_interlock #(.BYPASS(1'b1), .REG_W(RW), .ALU_ST(ALU), .MEM_ST(MEM), .FP_ST(FP)) i_pil_interlock_byp (
        .clk(clk), .rst(rst), .dec_valid(dv[1]), .dec_kind(dk[1]),
        .dec_src_a(dsa[1]), .dec_src_b(dsb[1]), .dec_dst(dd[1]),
        .stall(st[1]), .fwd_a(fa[1]), .fwd_b(fb[1]));

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ready_of(int k);
        case (k)
            0:       return ALU;
            1:       return ALU + MEM;
            3:       return FP;
            default: return 0;
        endcase
    endfunction

    task automatic idle_all();
        for (int m = 0; m < 2; m++) begin
            dv[m] = 1'b0; dk[m] = 2'd0; dsa[m] = '0; dsb[m] = '0; dd[m] = '0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle_all();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One producer, g empty slots, then one consumer whose chosen source matches.
    task automatic run_pair(int m, int pk, int ck, int sel, int g);
        int stalls, r, n, lim, ex, pidx, ef, used;
        int got_a, got_b;
        string tag;
        do_reset();
        dv[m] = 1'b1; dk[m] = 2'(pk); dd[m] = 5'd5; dsa[m] = 5'd1; dsb[m] = 5'd2;
        @(posedge clk);
        @(negedge clk);
        dv[m] = 1'b0;
        repeat (g) @(negedge clk);
        dv[m] = 1'b1; dk[m] = 2'(ck); dd[m] = 5'd6;
        dsa[m] = (sel == 0) ? 5'd5 : 5'd3;
        dsb[m] = (sel == 1) ? 5'd5 : 5'd4;
        stalls = 0;
        forever begin
            #1;
            if (!st[m] || stalls > 20) break;
            stalls++;
            @(negedge clk);
        end
        got_a = int'(fa[m]);
        got_b = int'(fb[m]);
        @(negedge clk);
        dv[m] = 1'b0;

        r    = ready_of(pk);
        used = (sel == 0 || ck != 1) ? 1 : 0;
        n    = (ck == 2 && sel == 1) ? ALU + 1 : 1;
        if (!used || pk == 2) lim = 0;
        else                  lim = (m == 1) ? r - n : r;
        ex = (lim - g > 0) ? lim - g : 0;
        if (!used || pk == 2)          tag = "R5";
        else if (m == 0)               tag = "R2";
        else if (ck == 2 && sel == 1)  tag = "R4";
        else                           tag = "R3";
        check(tag, $sformatf("stall cycles m=%0d p=%0d c=%0d s=%0d g=%0d", m, pk, ck, sel, g), stalls, ex);

        pidx = g + ex;
        ef   = (m == 1 && used == 1 && pk != 2 && pidx < r) ? ((pk == 0) ? 1 : (pk == 1) ? 2 : 3) : 0;
        check("R6", $sformatf("fwd dep m=%0d p=%0d c=%0d s=%0d g=%0d", m, pk, ck, sel, g),
              (sel == 0) ? got_a : got_b, ef);
        check("R6", $sformatf("fwd other m=%0d p=%0d c=%0d s=%0d g=%0d", m, pk, ck, sel, g),
              (sel == 0) ? got_b : got_a, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state, nothing tracked
        do_reset();
        for (int m = 0; m < 2; m++) begin
            dv[m] = 1'b1; dk[m] = 2'd3; dsa[m] = 5'd5; dsb[m] = 5'd0; dd[m] = 5'd7;
        end
        #1;
        for (int m = 0; m < 2; m++) begin
            check("R1", "stall after reset", int'(st[m]), 0);
            check("R1", "fwd_a after reset", int'(fa[m]), 0);
            check("R1", "fwd_b after reset", int'(fb[m]), 0);
        end

        // R7: an invalid slot carrying a destination creates no hazard
        for (int m = 0; m < 2; m++) begin
            do_reset();
            dv[m] = 1'b0; dk[m] = 2'd3; dd[m] = 5'd9;
            @(negedge clk);
            dv[m] = 1'b1; dk[m] = 2'd0; dsa[m] = 5'd9; dsb[m] = 5'd9; dd[m] = 5'd1;
            #1;
            check("R7", $sformatf("invalid slot hazard m=%0d", m), int'(st[m]), 0);
            @(negedge clk);
            dv[m] = 1'b0;
        end

        // R5: independent consumer after a long-latency producer
        for (int m = 0; m < 2; m++) begin
            do_reset();
            dv[m] = 1'b1; dk[m] = 2'd1; dd[m] = 5'd12; dsa[m] = 5'd1; dsb[m] = 5'd1;
            @(negedge clk);
            dk[m] = 2'd3; dd[m] = 5'd13; dsa[m] = 5'd2; dsb[m] = 5'd3;
            #1;
            check("R5", $sformatf("independent stall m=%0d", m), int'(st[m]), 0);
            @(negedge clk);
            dv[m] = 1'b0;
        end

        // Sweep: mode x producer kind x consumer kind x operand x gap
        for (int m = 0; m < 2; m++)
            for (int pk = 0; pk < 4; pk++)
                for (int ck = 0; ck < 4; ck++)
                    for (int sel = 0; sel < 2; sel++)
                        for (int g = 0; g < 6; g++)
                            run_pair(m, pk, ck, sel, g);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule